// File: doc/BRIEF.md
# Slot-Scheduled Video Write FIFO

This block buffers host CPU writes to video memory in a four-word ring and releases them only at fixed access-slot positions within each scan line. A free-running position counter tracks master cycles within the line. Each of two display-width modes has its own set of slot positions. On a slot with work pending, the oldest word goes out on a memory-write port. In byte-access mode a word needs two slots.

The host sees a full indication and two sticky status flags, full and empty. The width mode can be rewritten at any time. The new slot set is used from the cycle of the write onward, so a mid-line change takes hold at once. Pending words carry over from the end of one line into the first slots of the next.

Top module: `slot_write_fifo`

## Requirements
- R1: After reset the level is 0, the empty flag is 1, the full flag, host full and mem_we_o are 0, and the narrow slot set (mode value 0) is selected.
- R2: The line position runs from 0 to LINE_LEN-1 (3420) and wraps to 0. In narrow mode, slots fall at positions 230, 510, 810, 970, 1130, 1450, 1610, 1770, 2090, 2250, 2410, 2730, 2890, 3050, 3350 and 3370.
- R3: In wide mode (mode value 1), slots fall at positions 352, 820, 948, 1076, 1332, 1460, 1588, 1844, 1972, 2100, 2356, 2484, 2612, 2868, 2996, 3124, 3364 and 3380.
- R4: In word mode, a slot occurring while the level is non-zero pops the oldest word. mem_we_o is high in the following cycle, with that word on mem_data_o, and words leave in write order.
- R5: In byte mode, a word needs two slots that each occur while the level is non-zero. Only the second of the pair pops the word. Slots that occur while the level is zero are not counted.
- R6: A host write is accepted when the level is below 4. A write at level 4 is dropped and leaves the level unchanged. host_full_o is high exactly when the level is 4.
- R7: The full flag is set by a write that brings the level to 4. It is cleared by any pop.
- R8: The empty flag is set when the level reaches 0. It is cleared by an accepted write.
- R9: A mode write selects the new slot set for slot matching in the same cycle, and for every cycle after it.
- R10: Pending words not drained by the last slot of a line are drained by the first slots of the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host write strobe |
| wr_data_i | input | 16 | Host write word |
| byte_mode_i | input | 1 | 1: two slots per word |
| mode_we_i | input | 1 | Load width mode |
| mode_i | input | 1 | Width mode: 0 narrow, 1 wide |
| mem_we_o | output | 1 | Memory write strobe |
| mem_data_o | output | 16 | Memory write word |
| host_full_o | output | 1 | Buffer holds four words |
| stat_full_o | output | 1 | Sticky full status flag |
| stat_empty_o | output | 1 | Sticky empty status flag |
| level_o | output | 3 | Pending word count |

## Verification
The assertions check on every cycle that the level stays bounded and that a write at level 4 is not taken. They also check that a memory write follows only a slot, that the first slot of a byte pair writes nothing, and that the flags agree with the level. The bench's scenarios are needed to show that the slots sit at the exact listed positions, and that a mid-line mode change picks the new positions at once. They are also needed to show that draining carries across the line boundary and that words leave in order under mixed byte, word and mode patterns.

// File: rtl/swf_pkg.sv
package swf_pkg;
  typedef enum logic {MODE_NARROW = 1'b0, MODE_WIDE = 1'b1} width_mode_e;

  localparam int NARROW_SLOTS = 16;
  localparam int WIDE_SLOTS   = 18;

  function automatic int narrow_slot_pos(input int i);
    case (i)
      0: return 230;   1: return 510;   2: return 810;   3: return 970;
      4: return 1130;  5: return 1450;  6: return 1610;  7: return 1770;
      8: return 2090;  9: return 2250;  10: return 2410; 11: return 2730;
      12: return 2890; 13: return 3050; 14: return 3350; 15: return 3370;
      default: return 0;
    endcase
  endfunction

  function automatic int wide_slot_pos(input int i);
    case (i)
      0: return 352;   1: return 820;   2: return 948;   3: return 1076;
      4: return 1332;  5: return 1460;  6: return 1588;  7: return 1844;
      8: return 1972;  9: return 2100;  10: return 2356; 11: return 2484;
      12: return 2612; 13: return 2868; 14: return 2996; 15: return 3124;
      16: return 3364; 17: return 3380;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/swf_line_ctr.sv
module swf_line_ctr #(
  parameter int LINE_LEN = 3420,
  localparam int POS_W = $clog2(LINE_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else if (pos_q == POS_W'(LINE_LEN - 1)) pos_q <= '0;
    else pos_q <= pos_q + 1'b1;
  end

  assign pos_o = pos_q;

  a_r2_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_W'(LINE_LEN - 1));
  a_r10_pos_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_W'(LINE_LEN - 1)) |=> (pos_q == '0));
endmodule

// File: rtl/swf_slot_match.sv
module swf_slot_match
  import swf_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic             wide_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             slot_o
);
  logic [NARROW_SLOTS-1:0] hit_n;
  logic [WIDE_SLOTS-1:0]   hit_w;

  for (genvar i = 0; i < NARROW_SLOTS; i++) begin : g_narrow
    assign hit_n[i] = (pos_i == POS_W'(narrow_slot_pos(i)));
  end
  for (genvar i = 0; i < WIDE_SLOTS; i++) begin : g_wide
    assign hit_w[i] = (pos_i == POS_W'(wide_slot_pos(i)));
  end

  assign slot_o = wide_i ? |hit_w : |hit_n;
endmodule

// File: rtl/swf_ring.sv
module swf_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              slot_i,
  input  logic              byte_i,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              full_flag_o,
  output logic              empty_flag_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  widx_q, ridx_q;
  logic [LVL_W-1:0]  level_q, level_d;
  logic              half_q, half_d;
  logic              full_q, empty_q, we_q;
  logic [DATA_W-1:0] out_q;
  logic              accept, have, pop;

  assign accept  = wr_i && (level_q != LVL_W'(DEPTH));
  assign have    = (level_q != '0);
  assign pop     = slot_i && have && (!byte_i || half_q);
  assign level_d = level_q + LVL_W'(accept) - LVL_W'(pop);

  always_comb begin
    half_d = half_q;
    if (slot_i && have) half_d = byte_i && !half_q;
  end

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[widx_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q  <= '0;
      ridx_q  <= '0;
      level_q <= '0;
      half_q  <= 1'b0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      we_q    <= 1'b0;
      out_q   <= '0;
    end else begin
      level_q <= level_d;
      half_q  <= half_d;
      we_q    <= pop;
      if (accept) widx_q <= nxt(widx_q);
      if (pop) begin
        ridx_q <= nxt(ridx_q);
        out_q  <= mem_q[ridx_q];
      end
      if (accept && level_d == LVL_W'(DEPTH)) full_q <= 1'b1;
      else if (pop)                           full_q <= 1'b0;
      if (level_d == '0) empty_q <= 1'b1;
      else if (accept)   empty_q <= 1'b0;
    end
  end

  assign we_o         = we_q;
  assign wdata_o      = out_q;
  assign level_o      = level_q;
  assign full_flag_o  = full_q;
  assign empty_flag_o = empty_q;

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH));
  a_r6_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && level_q == LVL_W'(DEPTH)) |=> (level_q <= $past(level_q)));
  a_r4_write_after_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(slot_i));
  a_r5_first_half_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && byte_i && !half_q && have) |=> !we_q);
  a_r7_full_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> (level_q == LVL_W'(DEPTH)));
  a_r8_empty_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_q == (level_q == '0));
endmodule

// File: rtl/slot_write_fifo.sv
module slot_write_fifo
  import swf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 4,
  parameter int LINE_LEN = 3420,
  localparam int POS_W   = $clog2(LINE_LEN),
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              byte_mode_i,
  input  logic              mode_we_i,
  input  logic              mode_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              host_full_o,
  output logic              stat_full_o,
  output logic              stat_empty_o,
  output logic [LVL_W-1:0]  level_o
);
  width_mode_e      mode_q, mode_sel;
  logic [POS_W-1:0] pos;
  logic             slot;
  logic [LVL_W-1:0] level;

  // new mode governs slot matching in the cycle it is written
  assign mode_sel = mode_we_i ? width_mode_e'(mode_i) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_NARROW;
    else if (mode_we_i) mode_q <= width_mode_e'(mode_i);
  end

  swf_line_ctr #(.LINE_LEN(LINE_LEN)) u_line_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pos_o (pos)
  );

  swf_slot_match #(.POS_W(POS_W)) u_slot_match (
    .wide_i(mode_sel == MODE_WIDE),
    .pos_i (pos),
    .slot_o(slot)
  );

  swf_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_valid_i),
    .wdata_i     (wr_data_i),
    .slot_i      (slot),
    .byte_i      (byte_mode_i),
    .we_o        (mem_we_o),
    .wdata_o     (mem_data_o),
    .level_o     (level),
    .full_flag_o (stat_full_o),
    .empty_flag_o(stat_empty_o)
  );

  assign level_o     = level;
  assign host_full_o = (level == LVL_W'(DEPTH));

  a_r9_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_q == width_mode_e'($past(mode_i))));
  a_r6_host_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_full_o |-> !stat_empty_o);
endmodule

// File: tb/slot_write_fifo_bench.sv
module slot_write_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINE       = 3420;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wv = 1'b0, bm = 1'b0, mwe = 1'b0, md = 1'b0;
  logic [15:0] wd = '0;
  logic        mem_we, host_full, st_full, st_empty;
  logic [15:0] mem_data;
  logic [2:0]  level;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slot_write_fifo u_slot_write_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_data_i(wd),
    .byte_mode_i(bm), .mode_we_i(mwe), .mode_i(md),
    .mem_we_o(mem_we), .mem_data_o(mem_data), .host_full_o(host_full),
    .stat_full_o(st_full), .stat_empty_o(st_empty), .level_o(level)
  );

  int nar[16] = '{230, 510, 810, 970, 1130, 1450, 1610, 1770,
                  2090, 2250, 2410, 2730, 2890, 3050, 3350, 3370};
  int wid[18] = '{352, 820, 948, 1076, 1332, 1460, 1588, 1844, 1972,
                  2100, 2356, 2484, 2612, 2868, 2996, 3124, 3364, 3380};

  // reference state
  int          m_pos = 0, m_level = 0;
  bit          m_half = 0, m_full = 0, m_empty = 1, m_we = 0, m_mode = 0;
  logic [15:0] m_data = '0;
  logic [15:0] q[$];
  string       tag = "R4";
  int          wr_seq = 0;

  function automatic bit is_slot(bit wide, int p);
    if (wide) begin
      foreach (wid[i]) if (wid[i] == p) return 1;
    end else begin
      foreach (nar[i]) if (nar[i] == p) return 1;
    end
    return 0;
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d pos=%0d", rq, what, act, exp, m_pos);
    end
  endtask

  task automatic compare();
    chk(level == 3'(m_level), "R6", level, m_level, "level");
    chk(host_full == (m_level == 4), "R6", host_full, m_level == 4, "host_full");
    chk(st_full == m_full, "R7", st_full, m_full, "full_flag");
    chk(st_empty == m_empty, "R8", st_empty, m_empty, "empty_flag");
    chk(mem_we == m_we, tag, mem_we, m_we, "mem_we");
    if (m_we) chk(mem_data == m_data, tag, mem_data, m_data, "mem_data");
  endtask

  task automatic step(bit v, bit b, bit mw, bit mv);
    bit sel, hit, have, acc, pop;
    wv = v; bm = b; mwe = mw; md = mv;
    if (v) begin wd = 16'(16'hA000 + wr_seq * 16'h0137); wr_seq++; end
    @(posedge clk);
    sel  = mw ? mv : m_mode;
    hit  = is_slot(sel, m_pos);
    have = (m_level != 0);
    acc  = v && (m_level < 4);
    pop  = hit && have && (!b || m_half);
    if (hit && have) m_half = b && !m_half;
    m_we = pop;
    if (pop) m_data = q.pop_front();
    if (acc) q.push_back(wd);
    m_level = m_level + int'(acc) - int'(pop);
    if (acc && m_level == 4) m_full = 1;
    else if (pop) m_full = 0;
    if (m_level == 0) m_empty = 1;
    else if (acc) m_empty = 0;
    if (mw) m_mode = mv;
    m_pos = (m_pos == LINE - 1) ? 0 : m_pos + 1;
    @(negedge clk);
    wv = 0; mwe = 0;
    compare();
  endtask

  task automatic idle(int n, bit b);
    for (int i = 0; i < n; i++) step(0, b, 0, 0);
  endtask

  task automatic run_to(int p, bit b);
    while (m_pos != p) step(0, b, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(level == 0, "R1", level, 0, "level");
    chk(st_empty == 1, "R1", st_empty, 1, "empty_flag");
    chk(st_full == 0 && host_full == 0, "R1", st_full, 0, "full");
    chk(mem_we == 0, "R1", mem_we, 0, "mem_we");
    rst_n = 1'b1;

    // R2 R4 R6: narrow word mode, burst of 6 (two dropped)
    tag = "R2";
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0);
    run_to(240, 0);
    chk(m_level == 3, "R2", m_level, 3, "first narrow slot at 230");
    idle(LINE, 0);

    // R5: byte mode, two slots per word
    tag = "R5";
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
    idle(LINE, 1);

    // R3: wide word mode
    tag = "R3";
    step(0, 0, 1, 1);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    idle(LINE, 0);

    // R9: mid-line switch to narrow with entries pending, byte mode
    tag = "R9";
    run_to(100, 1);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
    run_to(900, 1);
    step(0, 1, 1, 0);
    run_to(970, 1);
    step(0, 1, 1, 1);  // wide selected at narrow slot 970: no slot this cycle
    chk(m_level == 3, "R9", level, 3, "switch in same cycle");
    idle(LINE, 1);

    // R10: drain carries across line end
    tag = "R10";
    step(0, 0, 1, 0);
    run_to(3300, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    run_to(3400, 0);
    chk(level == 2, "R10", level, 2, "after last narrow slots");
    run_to(600, 0);
    chk(level == 0, "R10", level, 0, "drained in next line");

    // R6 R7 R8: mixed traffic
    tag = "R4";
    for (int c = 0; c < 4 * LINE; c++)
      step((c % 97) < 3, (c / 500) % 2 == 1, (c % 1700) == 850, (c / 1700) % 2 == 0);
    idle(LINE, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule